// File: doc/BRIEF.md
# Parallel Poll Monitor Register Block

This block is the byte-wide register front end of a low-speed instrument-bus interface. A CPU reaches it through a simple write-strobe bus with a combinational read port. It has four standard registers and one hidden register. The standard registers are a status/DMA-control register, an auxiliary status register, a poll status/control register and an 8-bit poll mask. The hidden register holds the system-controller bit, which replaces a strap switch. The bus protocol engine is not part of this block. Its interrupt and its controller-in-charge status come in as plain inputs.

Software starts a parallel poll by setting the enable bit. From then on the block compares the eight poll response lines with the mask on every cycle. When the first unmasked response bit appears, the block ends the poll by itself and latches a sticky request. That request drives the level-3 interrupt output until software writes zero to the request bit.

Top module: `ppoll_regblk`

## Requirements
- R1: A hard/soft reset (`rstN` low) or a power-up reset (`porRstN` low) clears the poll enable bit, the request bit, all eight mask bits and the DMA enable. After either reset, offsets 0x7 and 0x9 read 0x00, and `dmaEn` and `pollIrq` are 0.
- R2: The hidden register is reached with `hiddenSel`=1 at offset 0x1 and holds the system-controller bit in bit 0. This bit is forced to 1 while `porRstN` is low and is left unchanged by `rstN`. It can be written by software, it drives `sysCtl`, and it reads back as bit 7 of offset 0x5.
- R3: Writing 1 to bit 7 of offset 0x7 sets the poll enable. In any cycle in which the enable is set and (`pollResp` AND mask) is non-zero, the next cycle has the request (bit 6 of 0x7) set and the enable cleared.
- R4: A response bit whose mask bit (offset 0x9) is 0 never ends a poll. The mask reads back as written.
- R5: `pollIrq` equals the request bit. The request stays set until a write to 0x7 with bit 6 = 0 clears it. A write with bit 6 = 1 leaves it unchanged.
- R6: Once a poll has ended, a response that still matches does not set the request again after software clears it, because the enable is already 0.
- R7: Offset 0x3 reads `ctlIrq` in bit 7 and the DMA enable in bit 0. Writing bit 0 sets or clears the DMA enable, which drives `dmaEn`.
- R8: Offset 0x5 reads the hidden SYS bit in bit 7, `ctlNotActive` in bit 6 (0 when the interface is controller in charge) and `kbdNmi` in bit 0.
- R9: Bits and offsets that are not defined read as 0, and writes to them change no register.
- R10: If a poll match and a write to 0x7 happen in the same cycle, the match wins: the request is set and the enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-up reset, active low, synchronous |
| rstN | input | 1 | Hard/soft reset, active low, synchronous |
| hiddenSel | input | 1 | Selects the hidden register set |
| addr | input | 5 | Register offset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from addr and hiddenSel |
| pollResp | input | 8 | Parallel poll response lines |
| ctlIrq | input | 1 | Interrupt from the bus controller |
| ctlNotActive | input | 1 | High when the interface is not controller in charge |
| kbdNmi | input | 1 | Keyboard non-maskable interrupt input |
| dmaEn | output | 1 | DMA channel 0 enable |
| pollIrq | output | 1 | Level-3 interrupt, high while the request is set |
| sysCtl | output | 1 | System-controller bit |

## Verification
On every cycle, the assertions check three things. A latched match always clears the enable in the same step. The request only rises from an enabled match and only falls through a clearing write or a reset. The SYS bit and the DMA enable change only through their own write strobes or a reset. Some behaviour is visible only in the bench scenarios: that masked-off response bits are ignored, that clearing after a stale match stays cleared, that a match takes priority over a concurrent write, and that the hidden bit survives a soft reset but is restored by power-up reset.

// File: rtl/ppoll_pkg.sv
package ppoll_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFF_HIDDEN = 5'h01;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 5'h03;
  localparam logic [ADDR_W-1:0] OFF_AUX    = 5'h05;
  localparam logic [ADDR_W-1:0] OFF_POLL   = 5'h07;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 5'h09;

  localparam int BIT_EN  = 7;
  localparam int BIT_REQ = 6;

  typedef struct packed {
    logic wrStat;
    logic wrPoll;
    logic wrMask;
    logic wrHidden;
  } strobes_t;
endpackage

// File: rtl/ppoll_ctrl.sv
module ppoll_ctrl
  import ppoll_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hiddenSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hit,
  output strobes_t          st,
  output logic              pollEn,
  output logic              pollReq
);
  always_comb begin
    st.wrStat   = wrEn && !hiddenSel && (addr == OFF_STAT);
    st.wrPoll   = wrEn && !hiddenSel && (addr == OFF_POLL);
    st.wrMask   = wrEn && !hiddenSel && (addr == OFF_MASK);
    st.wrHidden = wrEn &&  hiddenSel && (addr == OFF_HIDDEN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pollEn  <= 1'b0;
      pollReq <= 1'b0;
    end else if (pollEn && hit) begin
      pollEn  <= 1'b0;
      pollReq <= 1'b1;
    end else if (st.wrPoll) begin
      pollEn <= wrData[BIT_EN];
      if (!wrData[BIT_REQ]) pollReq <= 1'b0;
    end
  end

  // R3
  match_ends_poll_chk: assert property (@(posedge clk) disable iff (rst)
    (pollEn && hit) |=> (pollReq && !pollEn));

  // R3
  req_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pollReq) |-> $past(pollEn && hit));

  // R5
  req_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pollReq) |-> ($past(rst) || $past(st.wrPoll && !wrData[BIT_REQ])));
endmodule

// File: rtl/ppoll_dpath.sv
module ppoll_dpath
  import ppoll_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              porRstN,
  input  strobes_t          st,
  input  logic              hiddenSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pollResp,
  input  logic              ctlIrq,
  input  logic              ctlNotActive,
  input  logic              kbdNmi,
  input  logic              pollEn,
  input  logic              pollReq,
  output logic              hit,
  output logic [DATA_W-1:0] rdData,
  output logic              dmaEn,
  output logic              sysBit
);
  logic [DATA_W-1:0] maskReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      maskReg <= '0;
      dmaEn   <= 1'b0;
    end else begin
      if (st.wrMask) maskReg <= wrData;
      if (st.wrStat) dmaEn   <= wrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!porRstN)         sysBit <= 1'b1;
    else if (st.wrHidden) sysBit <= wrData[0];
  end

  assign hit = |(pollResp & maskReg);

  always_comb begin
    rdData = '0;
    if (hiddenSel) begin
      if (addr == OFF_HIDDEN) rdData[0] = sysBit;
    end else begin
      case (addr)
        OFF_STAT: begin
          rdData[7] = ctlIrq;
          rdData[0] = dmaEn;
        end
        OFF_AUX: begin
          rdData[7] = sysBit;
          rdData[6] = ctlNotActive;
          rdData[0] = kbdNmi;
        end
        OFF_POLL: begin
          rdData[BIT_EN]  = pollEn;
          rdData[BIT_REQ] = pollReq;
        end
        OFF_MASK: rdData = maskReg;
        default:  rdData = '0;
      endcase
    end
  end

  // R2
  sys_por_chk: assert property (@(posedge clk) !porRstN |=> sysBit);

  // R2
  sys_fall_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(sysBit) |-> $past(st.wrHidden));

  // R7
  dma_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dmaEn) |-> ($past(st.wrStat) || $past(rst)));
endmodule

// File: rtl/ppoll_regblk.sv
module ppoll_regblk
  import ppoll_pkg::*;
(
  input  logic              clk,
  input  logic              porRstN,
  input  logic              rstN,
  input  logic              hiddenSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] pollResp,
  input  logic              ctlIrq,
  input  logic              ctlNotActive,
  input  logic              kbdNmi,
  output logic              dmaEn,
  output logic              pollIrq,
  output logic              sysCtl
);
  logic     rst;
  logic     hit;
  logic     pollEn;
  logic     pollReq;
  strobes_t st;

  assign rst = !rstN || !porRstN;

  ppoll_ctrl ctrl_i (
    .clk(clk), .rst(rst), .hiddenSel(hiddenSel), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .hit(hit), .st(st), .pollEn(pollEn), .pollReq(pollReq)
  );

  ppoll_dpath dpath_i (
    .clk(clk), .rst(rst), .porRstN(porRstN), .st(st), .hiddenSel(hiddenSel),
    .addr(addr), .wrData(wrData), .pollResp(pollResp), .ctlIrq(ctlIrq),
    .ctlNotActive(ctlNotActive), .kbdNmi(kbdNmi), .pollEn(pollEn),
    .pollReq(pollReq), .hit(hit), .rdData(rdData), .dmaEn(dmaEn), .sysBit(sysCtl)
  );

  assign pollIrq = pollReq;

  // R5
  irq_tracks_req_chk: assert property (@(posedge clk) disable iff (rst)
    pollIrq == rdData[BIT_REQ] || hiddenSel || addr != OFF_POLL);
endmodule

// File: tb/ppoll_regblk_tb_top.sv
module ppoll_regblk_tb_top;
  logic       clk = 1'b0;
  logic       porRstN, rstN, hiddenSel, wrEn;
  logic [4:0] addr;
  logic [7:0] wrData, rdData, pollResp;
  logic       ctlIrq, ctlNotActive, kbdNmi, dmaEn, pollIrq, sysCtl;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ppoll_regblk dut_i (
    .clk(clk), .porRstN(porRstN), .rstN(rstN), .hiddenSel(hiddenSel),
    .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .pollResp(pollResp), .ctlIrq(ctlIrq), .ctlNotActive(ctlNotActive),
    .kbdNmi(kbdNmi), .dmaEn(dmaEn), .pollIrq(pollIrq), .sysCtl(sysCtl)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic hid, input logic [4:0] a, input logic [7:0] d);
    hiddenSel = hid; addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; hiddenSel = 1'b0;
  endtask

  task automatic rd(input logic hid, input logic [4:0] a, output logic [7:0] d);
    hiddenSel = hid; addr = a;
    #1 d = rdData;
    hiddenSel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    porRstN = 1'b0; rstN = 1'b0; idle(2);
    porRstN = 1'b1; rstN = 1'b1; idle(1);
    rd(0, 5'h07, v); check("R1 poll reg", v, 8'h00);
    rd(0, 5'h09, v); check("R1 mask", v, 8'h00);
    check("R1 dmaEn", dmaEn, 0);
    check("R1 pollIrq", pollIrq, 0);
    rd(1, 5'h01, v); check("R2 hidden por", v, 8'h01);
    check("R2 sysCtl", sysCtl, 1);
  endtask

  task automatic t_status_aux();
    logic [7:0] v;
    ctlIrq = 1'b1;
    rd(0, 5'h03, v); check("R7 irq read", v, 8'h80);
    wr(0, 5'h03, 8'h01);
    check("R7 dmaEn set", dmaEn, 1);
    rd(0, 5'h03, v); check("R7 read dma", v, 8'h81);
    wr(0, 5'hFF & 5'h03, 8'hFE);
    check("R7 dmaEn cleared", dmaEn, 0);
    ctlIrq = 1'b0;
    rd(0, 5'h03, v); check("R9 unused status bits", v, 8'h00);
    ctlNotActive = 1'b1; kbdNmi = 1'b1;
    rd(0, 5'h05, v); check("R8 aux all", v, 8'hC1);
    ctlNotActive = 1'b0;
    rd(0, 5'h05, v); check("R8 in charge", v, 8'h81);
    kbdNmi = 1'b0;
    wr(0, 5'h0B, 8'hFF);
    rd(0, 5'h0B, v); check("R9 unused offset", v, 8'h00);
    rd(0, 5'h09, v); check("R9 mask untouched", v, 8'h00);
    rd(0, 5'h01, v); check("R9 std 0x1 reads 0", v, 8'h00);
  endtask

  task automatic t_hidden();
    logic [7:0] v;
    wr(1, 5'h01, 8'hFE);
    rd(1, 5'h01, v); check("R2 hidden write", v, 8'h00);
    rd(0, 5'h05, v); check("R2 aux reflects", v, 8'h00);
    check("R2 sysCtl low", sysCtl, 0);
    rstN = 1'b0; idle(1); rstN = 1'b1; idle(1);
    rd(1, 5'h01, v); check("R2 soft reset keeps", v, 8'h00);
    porRstN = 1'b0; idle(1); porRstN = 1'b1; idle(1);
    rd(1, 5'h01, v); check("R2 por restores", v, 8'h01);
  endtask

  task automatic t_poll();
    logic [7:0] v;
    pollResp = 8'h0F;
    wr(0, 5'h09, 8'h10);
    rd(0, 5'h09, v); check("R4 mask readback", v, 8'h10);
    wr(0, 5'h07, 8'h80);
    rd(0, 5'h07, v); check("R3 enable set", v, 8'h80);
    idle(4);
    rd(0, 5'h07, v); check("R4 masked ignored", v, 8'h80);
    check("R4 no irq", pollIrq, 0);
    pollResp = 8'h1F;
    idle(1);
    rd(0, 5'h07, v); check("R3 match ends poll", v, 8'h40);
    check("R5 irq high", pollIrq, 1);
    idle(3);
    check("R5 irq holds", pollIrq, 1);
    wr(0, 5'h07, 8'h40);
    rd(0, 5'h07, v); check("R5 write one no effect", v, 8'h40);
    wr(0, 5'h07, 8'h00);
    check("R5 cleared", pollIrq, 0);
    idle(3);
    rd(0, 5'h07, v); check("R6 stale no re-set", v, 8'h00);
    check("R6 irq stays low", pollIrq, 0);
  endtask

  task automatic t_conflict();
    logic [7:0] v;
    pollResp = 8'h00;
    wr(0, 5'h09, 8'hFF);
    wr(0, 5'h07, 8'h80);
    pollResp = 8'h01;
    wr(0, 5'h07, 8'h80);
    rd(0, 5'h07, v); check("R10 match wins", v, 8'h40);
    wr(0, 5'h03, 8'h01);
    rstN = 1'b0; idle(1); rstN = 1'b1; idle(1);
    rd(0, 5'h07, v); check("R1 soft reset poll", v, 8'h00);
    rd(0, 5'h09, v); check("R1 soft reset mask", v, 8'h00);
    check("R1 soft reset dma", dmaEn, 0);
    check("R1 soft reset irq", pollIrq, 0);
    pollResp = 8'h00;
  endtask

  initial begin
    porRstN = 1'b0; rstN = 1'b0; hiddenSel = 1'b0; wrEn = 1'b0;
    addr = '0; wrData = '0; pollResp = '0;
    ctlIrq = 1'b0; ctlNotActive = 1'b0; kbdNmi = 1'b0;
    @(negedge clk);
    t_reset();
    t_status_aux();
    t_hidden();
    t_poll();
    t_conflict();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired got=0x1 exp=0x0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule